// File: doc/BRIEF.md
# Burst-Synchronised Slot Clock Generator

This block builds the per-frame timing of a loop-terminal slave from a fast system clock. Each time the receiver reports a demodulated master burst with a one-cycle sync pulse, the block restarts a frame. It emits a bit clock, two complementary slot enables and a slow clock for the two low-rate side channels. Each of these clocks runs for a fixed number of periods and then rests low. Because the frame restarts on every burst, any drift between master and slave is discarded once per frame.

The same frame counter drives the serial data paths. The two 8-bit bearer octets captured at the burst leave on one serial line, MSB first, and change on bit-clock rising edges. The octets on the serial input are sampled on bit-clock falling edges and delivered in parallel. The two side channels move two bits each per frame on the slow clock in the same manner. A one-bit frame flag is also latched at each burst.

Top module: `burst_slot_timer`

## Requirements
- R1: While reset is high and after it, until the first sync pulse, all clocks, slot 1 enable, serial outputs, parallel data and valid strobes are 0, and slot 2 enable is 1.
- R2: In the cycle after a sync pulse the bit clock goes high. It has a period of CLK_PER_BIT (64) system cycles, high for the first half. It gives exactly 16 periods (1024 cycles) and then stays low.
- R3: Slot 1 enable is high for the first 8 bit-clock periods (512 cycles) after the sync pulse and low otherwise. Slot 2 enable is always its inverse. Slot 1 falls together with a bit-clock rise.
- R4: The side-channel clock starts high together with the bit clock and slot 1 enable. It has a period of 512 cycles, high for the first half. It gives exactly 2 periods and then stays low.
- R5: A sync pulse that arrives while a frame is running, including in its last cycle, restarts the frame from its first cycle in the next cycle.
- R6: The word {octet 1, octet 2} is captured in the sync cycle. Its bit 15 − k drives the serial output during bit-clock period k. The output is 0 between frames. Changes to the parallel inputs at other times have no effect.
- R7: The serial input is sampled in the first cycle that the bit clock is low in each period. Samples 0–7 form octet 1 and samples 8–15 form octet 2, with the first sample as bit 7. Each octet appears in the cycle after its 8th sample with a one-cycle valid pulse and is then held. The octet 1 pulse falls while slot 1 is high and the octet 2 pulse while it is low.
- R8: Each side channel sends its 2-bit word, captured in the sync cycle, with bit 1 in clock period 0 and bit 0 in period 1. The output is 0 between frames.
- R9: Each side-channel input is sampled in the first low cycle of each side-channel period. The 2-bit pair, first sample as bit 1, appears in the cycle after the second sample with a shared one-cycle valid pulse.
- R10: The frame flag output takes the flag input captured in the sync cycle, so it changes only as slot 1 enable rises, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8.192 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | One-cycle pulse: master burst demodulated |
| flag_i | input | 1 | Frame flag value to latch at burst |
| oct1_tx_i | input | 8 | Bearer octet 1 to send |
| oct2_tx_i | input | 8 | Bearer octet 2 to send |
| ser_rx_i | input | 1 | Bearer serial input |
| side1_tx_i | input | 2 | Side channel 1 bits to send |
| side2_tx_i | input | 2 | Side channel 2 bits to send |
| side1_rx_i | input | 1 | Side channel 1 serial input |
| side2_rx_i | input | 1 | Side channel 2 serial input |
| slot1_en_o | output | 1 | Slot 1 enable, frame reference |
| slot2_en_o | output | 1 | Slot 2 enable, inverse of slot 1 |
| bit_clk_o | output | 1 | Gated bearer bit clock |
| side_clk_o | output | 1 | Gated side-channel clock |
| ser_tx_o | output | 1 | Bearer serial output |
| side1_tx_o | output | 1 | Side channel 1 serial output |
| side2_tx_o | output | 1 | Side channel 2 serial output |
| oct1_rx_o | output | 8 | Received octet 1 |
| oct1_rx_vld_o | output | 1 | Octet 1 valid pulse |
| oct2_rx_o | output | 8 | Received octet 2 |
| oct2_rx_vld_o | output | 1 | Octet 2 valid pulse |
| side1_rx_o | output | 2 | Received side channel 1 bits |
| side2_rx_o | output | 2 | Received side channel 2 bits |
| side_rx_vld_o | output | 1 | Side-channel pair valid pulse |
| flag_o | output | 1 | Latched frame flag |

## Verification
All outputs come from one frame counter, so a wrong counter value or live flag shows up within one system cycle. The bit clock, slot enables or side-channel clock would change in a cycle other than the one the reference predicts. A serial output would show the wrong bit of the captured word. A fault in a receive shifter shows only when its octet or pair is delivered, up to 1024 cycles after the sample that was lost. Restarts in mid-frame and in the last cycle of a frame check that the sync pulse takes priority over the end of a frame.

// File: rtl/bst_pkg.sv
package bst_pkg;

    // Per-cycle frame events decoded from the frame counter
    typedef struct packed {
        logic live;      // a frame is in progress
        logic bit_clk;   // gated bearer bit clock level
        logic slot1;     // slot 1 enable level
        logic side_clk;  // gated side-channel clock level
        logic b_smp;     // first low cycle of a bit-clock period
        logic b1_last;   // sample closes octet 1
        logic b2_last;   // sample closes octet 2
        logic d_smp;     // first low cycle of a side-clock period
        logic d_last;    // sample closes the side-channel pair
    } bst_evt_t;

    function automatic bit bst_is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/bst_frame_ctr.sv
module bst_frame_ctr
    import bst_pkg::*;
#(
    parameter int unsigned CLK_PER_BIT = 64,
    parameter int unsigned B_BITS      = 8,
    parameter int unsigned D_BITS      = 2,
    parameter int          BIW         = $clog2(2 * B_BITS),
    parameter int          DIW         = $clog2(D_BITS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sync_i,
    output bst_evt_t       evt_o,
    output logic [BIW-1:0] b_idx_o,
    output logic [DIW-1:0] d_idx_o
);
    localparam int unsigned FRAME_CLKS   = CLK_PER_BIT * 2 * B_BITS;
    localparam int unsigned CLK_PER_DBIT = FRAME_CLKS / D_BITS;
    localparam int          CW           = $clog2(FRAME_CLKS);
    localparam int          PW           = $clog2(CLK_PER_BIT);
    localparam int          DPW          = $clog2(CLK_PER_DBIT);
    localparam bit          SHAPE_OK     = bst_is_pow2(CLK_PER_BIT) && bst_is_pow2(B_BITS)
                                           && bst_is_pow2(D_BITS) && (D_BITS >= 2);

    logic          live_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] b_ph;
    logic [DPW-1:0] d_ph;

    always_ff @(posedge clk) begin
        if (rst || !SHAPE_OK) begin
            live_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sync_i) begin
            live_q <= 1'b1;
            cnt_q  <= '0;
        end else if (live_q) begin
            if (cnt_q == CW'(FRAME_CLKS - 1)) begin
                live_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign b_ph    = cnt_q[PW-1:0];
    assign d_ph    = cnt_q[DPW-1:0];
    assign b_idx_o = cnt_q[CW-1:PW];
    assign d_idx_o = cnt_q[CW-1:DPW];

    always_comb begin
        evt_o          = '0;
        evt_o.live     = live_q;
        evt_o.bit_clk  = live_q & ~b_ph[PW-1];
        evt_o.slot1    = live_q & ~cnt_q[CW-1];
        evt_o.side_clk = live_q & ~d_ph[DPW-1];
        evt_o.b_smp    = live_q && (b_ph == PW'(CLK_PER_BIT / 2));
        evt_o.b1_last  = evt_o.b_smp && (b_idx_o == BIW'(B_BITS - 1));
        evt_o.b2_last  = evt_o.b_smp && (b_idx_o == BIW'(2 * B_BITS - 1));
        evt_o.d_smp    = live_q && (d_ph == DPW'(CLK_PER_DBIT / 2));
        evt_o.d_last   = evt_o.d_smp && (d_idx_o == DIW'(D_BITS - 1));
    end

endmodule

// File: rtl/bst_tx_ser.sv
module bst_tx_ser #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [W-1:0]  word_i,
    input  logic          live_i,
    input  logic [IW-1:0] idx_i,
    output logic          bit_o
);
    logic [W-1:0]  word_q;
    logic [IW-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load_i) begin
            word_q <= word_i;
        end
    end

    // MSB leaves first: period k carries bit W-1-k
    assign sel   = IW'(W - 1) - idx_i;
    assign bit_o = live_i & word_q[sel];

endmodule

// File: rtl/bst_rx_shift.sv
module bst_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_i,
    input  logic         last_i,
    input  logic         din_i,
    output logic [W-1:0] data_o,
    output logic         valid_o
);
    logic [W-2:0] sh_q;
    logic [W-1:0] nxt;

    assign nxt = {sh_q, din_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= smp_i & last_i;
            if (smp_i) begin
                sh_q <= nxt[W-2:0];
                if (last_i) begin
                    data_o <= nxt;
                end
            end
        end
    end

endmodule

// File: rtl/burst_slot_timer.sv
module burst_slot_timer
    import bst_pkg::*;
#(
    parameter int unsigned CLK_PER_BIT = 64,
    parameter int unsigned B_BITS      = 8,
    parameter int unsigned D_BITS      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              flag_i,
    input  logic [B_BITS-1:0] oct1_tx_i,
    input  logic [B_BITS-1:0] oct2_tx_i,
    input  logic              ser_rx_i,
    input  logic [D_BITS-1:0] side1_tx_i,
    input  logic [D_BITS-1:0] side2_tx_i,
    input  logic              side1_rx_i,
    input  logic              side2_rx_i,
    output logic              slot1_en_o,
    output logic              slot2_en_o,
    output logic              bit_clk_o,
    output logic              side_clk_o,
    output logic              ser_tx_o,
    output logic              side1_tx_o,
    output logic              side2_tx_o,
    output logic [B_BITS-1:0] oct1_rx_o,
    output logic              oct1_rx_vld_o,
    output logic [B_BITS-1:0] oct2_rx_o,
    output logic              oct2_rx_vld_o,
    output logic [D_BITS-1:0] side1_rx_o,
    output logic [D_BITS-1:0] side2_rx_o,
    output logic              side_rx_vld_o,
    output logic              flag_o
);
    localparam int BW     = 2 * B_BITS;
    localparam int BIW    = $clog2(BW);
    localparam int DIW    = $clog2(D_BITS);
    localparam int N_SIDE = 2;
    localparam int N_OCT  = 2;

    bst_evt_t       evt;
    logic [BIW-1:0] b_idx;
    logic [DIW-1:0] d_idx;

    bst_frame_ctr #(
        .CLK_PER_BIT(CLK_PER_BIT),
        .B_BITS     (B_BITS),
        .D_BITS     (D_BITS),
        .BIW        (BIW),
        .DIW        (DIW)
    ) i_ctr (
        .clk    (clk),
        .rst    (rst),
        .sync_i (sync_i),
        .evt_o  (evt),
        .b_idx_o(b_idx),
        .d_idx_o(d_idx)
    );

    assign bit_clk_o  = evt.bit_clk;
    assign slot1_en_o = evt.slot1;
    assign slot2_en_o = ~evt.slot1;
    assign side_clk_o = evt.side_clk;

    // Bearer transmit: both octets as one word, octet 1 first
    bst_tx_ser #(.W(BW), .IW(BIW)) i_btx (
        .clk   (clk),
        .rst   (rst),
        .load_i(sync_i),
        .word_i({oct1_tx_i, oct2_tx_i}),
        .live_i(evt.live),
        .idx_i (b_idx),
        .bit_o (ser_tx_o)
    );

    // Side-channel transmit and receive, one lane per channel
    logic [D_BITS-1:0] side_word [N_SIDE];
    logic              side_din  [N_SIDE];
    logic              side_dout [N_SIDE];
    logic [D_BITS-1:0] side_rx   [N_SIDE];
    logic              side_vld  [N_SIDE];

    assign side_word[0] = side1_tx_i;
    assign side_word[1] = side2_tx_i;
    assign side_din[0]  = side1_rx_i;
    assign side_din[1]  = side2_rx_i;

    for (genvar c = 0; c < N_SIDE; c++) begin : g_side
        bst_tx_ser #(.W(D_BITS), .IW(DIW)) i_dtx (
            .clk   (clk),
            .rst   (rst),
            .load_i(sync_i),
            .word_i(side_word[c]),
            .live_i(evt.live),
            .idx_i (d_idx),
            .bit_o (side_dout[c])
        );
        bst_rx_shift #(.W(D_BITS)) i_drx (
            .clk    (clk),
            .rst    (rst),
            .smp_i  (evt.d_smp),
            .last_i (evt.d_last),
            .din_i  (side_din[c]),
            .data_o (side_rx[c]),
            .valid_o(side_vld[c])
        );
    end

    assign side1_tx_o    = side_dout[0];
    assign side2_tx_o    = side_dout[1];
    assign side1_rx_o    = side_rx[0];
    assign side2_rx_o    = side_rx[1];
    assign side_rx_vld_o = side_vld[0] & side_vld[1];

    // Bearer receive: each lane keeps the last B_BITS samples, closed by its own index
    logic [B_BITS-1:0] oct_rx  [N_OCT];
    logic              oct_vld [N_OCT];

    for (genvar c = 0; c < N_OCT; c++) begin : g_oct
        bst_rx_shift #(.W(B_BITS)) i_brx (
            .clk    (clk),
            .rst    (rst),
            .smp_i  (evt.b_smp),
            .last_i ((c == 0) ? evt.b1_last : evt.b2_last),
            .din_i  (ser_rx_i),
            .data_o (oct_rx[c]),
            .valid_o(oct_vld[c])
        );
    end

    assign oct1_rx_o     = oct_rx[0];
    assign oct2_rx_o     = oct_rx[1];
    assign oct1_rx_vld_o = oct_vld[0];
    assign oct2_rx_vld_o = oct_vld[1];

    // Frame flag follows the start of slot 1
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (sync_i) begin
            flag_o <= flag_i;
        end
    end

endmodule

// File: rtl/bst_checker.sv
module bst_checker (
    input logic clk,
    input logic rst,
    input logic sync_i,
    input logic slot1_en_o,
    input logic bit_clk_o,
    input logic side_clk_o,
    input logic oct1_rx_vld_o,
    input logic oct2_rx_vld_o,
    input logic side_rx_vld_o,
    input logic flag_o
);
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (bit_clk_o && slot1_en_o && side_clk_o)); // R5

    AST_SLOT1_ENDS_ON_BIT_RISE: assert property (@(posedge clk) disable iff (rst)
        $fell(slot1_en_o) |-> $rose(bit_clk_o)); // R3

    AST_SIDE_RISE_ON_BIT_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(side_clk_o) && !$past(sync_i)) |-> $rose(bit_clk_o)); // R4

    AST_OCT1_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        oct1_rx_vld_o |=> !oct1_rx_vld_o); // R7

    AST_OCT1_IN_SLOT1: assert property (@(posedge clk) disable iff (rst)
        (oct1_rx_vld_o && !$past(sync_i)) |-> slot1_en_o); // R7

    AST_OCT2_AFTER_SLOT1: assert property (@(posedge clk) disable iff (rst)
        (oct2_rx_vld_o && !$past(sync_i)) |-> !slot1_en_o); // R7

    AST_SIDE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        side_rx_vld_o |=> !side_rx_vld_o); // R9

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(sync_i) |-> $stable(flag_o)); // R10

endmodule

bind burst_slot_timer bst_checker i_bst_checker (
    .clk          (clk),
    .rst          (rst),
    .sync_i       (sync_i),
    .slot1_en_o   (slot1_en_o),
    .bit_clk_o    (bit_clk_o),
    .side_clk_o   (side_clk_o),
    .oct1_rx_vld_o(oct1_rx_vld_o),
    .oct2_rx_vld_o(oct2_rx_vld_o),
    .side_rx_vld_o(side_rx_vld_o),
    .flag_o       (flag_o)
);

// File: tb/test_burst_slot_timer.sv
module test_burst_slot_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CPB   = 64;
    localparam int FRAME = CPB * 16;
    localparam int CPD   = FRAME / 2;

    logic clk = 1'b0, rst = 1'b1, sync = 1'b0, flag_in = 1'b0;
    logic [7:0] o1_in = '0, o2_in = '0;
    logic [1:0] s1_in = '0, s2_in = '0;
    logic ser_rx = 1'b0, s1_rx = 1'b0, s2_rx = 1'b0;

    logic slot1, slot2, bclk, sclk, ser_tx, s1_tx, s2_tx;
    logic [7:0] o1_rx, o2_rx;
    logic o1_v, o2_v, s_v, flag_out;
    logic [1:0] s1_out, s2_out;

    burst_slot_timer i_burst_slot_timer (
        .clk(clk), .rst(rst), .sync_i(sync), .flag_i(flag_in),
        .oct1_tx_i(o1_in), .oct2_tx_i(o2_in), .ser_rx_i(ser_rx),
        .side1_tx_i(s1_in), .side2_tx_i(s2_in), .side1_rx_i(s1_rx), .side2_rx_i(s2_rx),
        .slot1_en_o(slot1), .slot2_en_o(slot2), .bit_clk_o(bclk), .side_clk_o(sclk),
        .ser_tx_o(ser_tx), .side1_tx_o(s1_tx), .side2_tx_o(s2_tx),
        .oct1_rx_o(o1_rx), .oct1_rx_vld_o(o1_v), .oct2_rx_o(o2_rx), .oct2_rx_vld_o(o2_v),
        .side1_rx_o(s1_out), .side2_rx_o(s2_out), .side_rx_vld_o(s_v), .flag_o(flag_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit cmp_on = 0, done = 0;

    // Behavioural reference: time since burst and captured words
    bit m_live;
    int m_t, m_btx, m_s1w, m_s2w, bacc, s1acc, s2acc;
    int e_o1, e_o2, e_s1, e_s2;
    bit e_o1v, e_o2v, e_sv, e_flag;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_live = 0; m_t = 0; m_btx = 0; m_s1w = 0; m_s2w = 0;
            bacc = 0; s1acc = 0; s2acc = 0;
            e_o1 = 0; e_o2 = 0; e_s1 = 0; e_s2 = 0;
            e_o1v = 0; e_o2v = 0; e_sv = 0; e_flag = 0;
        end else begin
            e_o1v = 0; e_o2v = 0; e_sv = 0;
            if (m_live && (m_t % CPB) == CPB / 2) begin
                bacc = ((bacc << 1) | int'(ser_rx)) & 255;
                if (m_t / CPB == 7)  begin e_o1 = bacc; e_o1v = 1; end
                if (m_t / CPB == 15) begin e_o2 = bacc; e_o2v = 1; end
            end
            if (m_live && (m_t % CPD) == CPD / 2) begin
                s1acc = ((s1acc << 1) | int'(s1_rx)) & 3;
                s2acc = ((s2acc << 1) | int'(s2_rx)) & 3;
                if (m_t / CPD == 1) begin e_s1 = s1acc; e_s2 = s2acc; e_sv = 1; end
            end
            if (sync) begin
                m_live = 1; m_t = 0;
                m_btx = {16'd0, o1_in, o2_in};
                m_s1w = int'(s1_in); m_s2w = int'(s2_in);
                e_flag = flag_in;
            end else if (m_live) begin
                if (m_t == FRAME - 1) begin m_live = 0; m_t = 0; end
                else m_t++;
            end
        end
    end

    // Per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 bit clock", bclk, m_live && (m_t % CPB) < CPB / 2);
            chk("R3 slot1 enable", slot1, m_live && m_t < FRAME / 2);
            chk("R3 slot2 inverse", slot2, !(m_live && m_t < FRAME / 2));
            chk("R4 side clock", sclk, m_live && (m_t % CPD) < CPD / 2);
            chk("R6 serial out", ser_tx, m_live ? (m_btx >> (15 - m_t / CPB)) & 1 : 0);
            chk("R8 side1 out", s1_tx, m_live ? (m_s1w >> (1 - m_t / CPD)) & 1 : 0);
            chk("R8 side2 out", s2_tx, m_live ? (m_s2w >> (1 - m_t / CPD)) & 1 : 0);
            chk("R7 octet1 data", o1_rx, e_o1);
            chk("R7 octet1 valid", o1_v, e_o1v);
            chk("R7 octet2 data", o2_rx, e_o2);
            chk("R7 octet2 valid", o2_v, e_o2v);
            chk("R9 side1 pair", s1_out, e_s1);
            chk("R9 side2 pair", s2_out, e_s2);
            chk("R9 side valid", s_v, e_sv);
            chk("R10 frame flag", flag_out, e_flag);
        end
    end

    // Serial inputs wander every cycle
    always @(negedge clk) begin
        ser_rx <= 1'($urandom);
        s1_rx  <= 1'($urandom);
        s2_rx  <= 1'($urandom);
    end

    task automatic run_frame(input int gap, input bit count_edges);
        int br, dr;
        logic pb, pd;
        @(negedge clk);
        sync = 1'b1;
        o1_in = 8'($urandom); o2_in = 8'($urandom);
        s1_in = 2'($urandom); s2_in = 2'($urandom);
        flag_in = 1'($urandom);
        pb = bclk; pd = sclk;
        @(negedge clk);
        sync = 1'b0;
        // R5: frame (re)starts in the cycle after the sync pulse
        chk("R5 restart bit clock", bclk, 1);
        chk("R5 restart slot1", slot1, 1);
        chk("R5 restart side clock", sclk, 1);
        br = (pb == 1'b0) ? 1 : 0;
        dr = (pd == 1'b0) ? 1 : 0;
        pb = 1'b1; pd = 1'b1;
        // R6 R10: inputs changed outside the sync cycle must not matter
        o1_in = ~o1_in; o2_in = ~o2_in; s1_in = ~s1_in; s2_in = ~s2_in; flag_in = ~flag_in;
        for (int i = 1; i < gap; i++) begin
            @(negedge clk);
            if (bclk && !pb) br++;
            if (sclk && !pd) dr++;
            pb = bclk; pd = sclk;
        end
        if (count_edges) begin
            chk("R2 bit clock periods per frame", br, 16);
            chk("R4 side clock periods per frame", dr, 2);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 bit clock", bclk, 0);
        chk("R1 slot1", slot1, 0);
        chk("R1 slot2", slot2, 1);
        chk("R1 side clock", sclk, 0);
        chk("R1 serial out", ser_tx, 0);
        chk("R1 valids", {o1_v, o2_v, s_v}, 0);
        chk("R1 data", {o1_rx, o2_rx, s1_out, s2_out, flag_out}, 0);
        rst = 1'b0;
        cmp_on = 1;
        repeat (20) @(negedge clk);
        chk("R1 idle before first sync", {bclk, slot1, sclk, slot2}, 1);
        run_frame(1100, 1);
        run_frame(1100, 1);
        run_frame(300, 0);
        run_frame(700, 0);
        run_frame(1023, 0);
        run_frame(1100, 0);
        run_frame(1100, 1);
        repeat (200) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule